// File: doc/BRIEF.md
# Priority Flow Control Receive Filter

This block sits in a receive datapath after frame parsing and inspects each incoming frame for the MAC control header. It recognises two kinds of control frame. The first is the standard single-class pause frame. The second is the priority-based flow control (PFC) frame, which carries a class-enable vector and eight per-class pause quanta.

For a PFC frame, every supported priority that the frame enables and that is not locally ignored gets a one-cycle pause request on its own lane, together with its quanta. These lanes feed the transmit-side client logic. A standard pause frame produces a single pause request unless that kind of frame is set to be ignored.

All frames cross a fixed 16-cycle delay line, which gives the block time to see the type and opcode before the first byte leaves. PFC frames are removed from the outgoing stream by default. A forward-enable bit delivers them instead, and they are still acted on either way. Bytes of one frame must arrive on consecutive cycles, from the start beat to the end beat. Quanta countdown and FCS checking belong to other blocks.

Top module: `pfc_rx_filter`

## Requirements
- R1: `NPRIO` (2 to 8) sets the number of pause lanes. Class-enable bits at position `NPRIO` and above never raise a pause request.
- R2: A frame is PFC when byte offsets 12–13 hold 0x8808 and offsets 14–15 hold 0x0101. Offsets 16–17 carry the class-enable vector, high byte first, and bit n of that vector selects priority n. The quanta for priority n sits at offsets 18+2n (high byte) and 19+2n (low byte).
- R3: One cycle after the end byte of a PFC frame of at least 34 bytes is accepted with `in_err` low, `pause_valid[n]` pulses for exactly one cycle for each requested lane. `pause_quanta[16n+15:16n]` holds that lane's quanta during the pulse. An errored or shorter PFC frame raises no request.
- R4: A lane whose `cfg_pfc_ignore[n]` bit is 1 at the end byte raises no request. The other lanes are unaffected.
- R5: With `cfg_fwd_pfc` at 0 when offset 15 is accepted, no byte of a PFC frame appears on the output. This holds whether or not the frame raised requests or carried an error.
- R6: With `cfg_fwd_pfc` at 1, a PFC frame is delivered unchanged and its requests are still raised.
- R7: A frame with type 0x8808 and opcode 0x0001 that is at least 18 bytes long and ends without error pulses `std_pause_valid` one cycle after its end byte, with `std_pause_quanta` equal to offsets 16–17 (high byte first). There is no pulse while `cfg_ignore_std` is 1. Such frames are always delivered.
- R8: Every frame that is not a PFC frame is delivered byte for byte, with start, end and error flags intact and a latency of 16 cycles. This covers other opcodes, other types and frames shorter than 16 bytes.
- R9: A standard pause pulse and PFC lane pulses never occur in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte valid |
| in_sop | input | 1 | First byte of frame |
| in_eop | input | 1 | Last byte of frame |
| in_err | input | 1 | Frame error, meaningful with in_eop |
| in_data | input | 8 | Input byte |
| cfg_ignore_std | input | 1 | Suppress standard pause requests |
| cfg_pfc_ignore | input | NPRIO | Per-lane PFC suppression, 1 = ignore |
| cfg_fwd_pfc | input | 1 | Deliver PFC frames to the client |
| out_valid | output | 1 | Output byte valid |
| out_sop | output | 1 | First output byte of frame |
| out_eop | output | 1 | Last output byte of frame |
| out_err | output | 1 | Output frame error |
| out_data | output | 8 | Output byte |
| std_pause_valid | output | 1 | Standard pause request pulse |
| std_pause_quanta | output | 16 | Standard pause quanta |
| pause_valid | output | NPRIO | Per-lane PFC request pulses |
| pause_quanta | output | 16*NPRIO | Per-lane quanta, lane n at bits 16n+15:16n |

## Verification
The hardest state to reach is the handover of the drop decision between neighbouring frames. The decision for one frame is made only when its offset-15 byte arrives, while the tail of the previous frame may still be draining through the delay line. A short frame never reaches offset 15 at all. The bench sends a dropped PFC frame immediately followed, with no idle cycle, by a short data frame. It then checks that exactly the short frame's bytes emerge. Table rows also cover frames of exactly 34 bytes, truncated frames and errored frames, which probe the length and error gating of the pause pulses.

// File: rtl/pfc_rx_filter.sv
module pfc_rx_filter #(
  parameter int NPRIO = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic                 in_sop,
  input  logic                 in_eop,
  input  logic                 in_err,
  input  logic [7:0]           in_data,
  input  logic                 cfg_ignore_std,
  input  logic [NPRIO-1:0]     cfg_pfc_ignore,
  input  logic                 cfg_fwd_pfc,
  output logic                 out_valid,
  output logic                 out_sop,
  output logic                 out_eop,
  output logic                 out_err,
  output logic [7:0]           out_data,
  output logic                 std_pause_valid,
  output logic [15:0]          std_pause_quanta,
  output logic [NPRIO-1:0]     pause_valid,
  output logic [NPRIO*16-1:0]  pause_quanta
);
  localparam int DLY      = 16;
  localparam int CW       = 6;
  localparam int HDR_LAST = 15;
  localparam int PFC_LAST = 18 + 2*8 - 1;
  localparam int STD_LAST = 17;

  logic [CW-1:0]    cnt, idx;
  logic [7:0]       b12, b13, b14, qhi, std_hi;
  logic [NPRIO-1:0] cev;
  logic [15:0]      std_q;
  logic [15:0]      qcap [NPRIO];
  logic             is_pfc, is_std, drop_cls, frame_drop;
  logic [11:0]      pipe [DLY];

  assign idx = in_sop ? '0 : cnt;

  wire [31:0] hdr     = {b12, b13, b14, in_data};
  wire        pfc_hit = hdr == 32'h8808_0101;
  wire        std_hit = hdr == 32'h8808_0001;
  wire        fin     = in_valid && in_eop && !in_err;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt      <= '0;
      is_pfc   <= 1'b0;
      is_std   <= 1'b0;
      drop_cls <= 1'b0;
    end else if (in_valid) begin
      cnt <= (idx == '1) ? idx : idx + 1'b1;
      if (idx == '0) begin
        is_pfc <= 1'b0;
        is_std <= 1'b0;
      end
      if (in_eop && idx < CW'(HDR_LAST)) drop_cls <= 1'b0;
      case (idx)
        CW'(12): b12 <= in_data;
        CW'(13): b13 <= in_data;
        CW'(14): b14 <= in_data;
        CW'(HDR_LAST): begin
          is_pfc   <= pfc_hit;
          is_std   <= std_hit;
          drop_cls <= pfc_hit && !cfg_fwd_pfc;
        end
        CW'(16): std_hi <= in_data;
        CW'(17): begin
          cev   <= in_data[NPRIO-1:0];
          std_q <= {std_hi, in_data};
        end
        default: ;
      endcase
      if (idx >= CW'(18) && idx <= CW'(PFC_LAST) && !idx[0]) qhi <= in_data;
      for (int i = 0; i < NPRIO; i++)
        if (idx == CW'(19 + 2*i)) qcap[i] <= {qhi, in_data};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pause_valid     <= '0;
      std_pause_valid <= 1'b0;
    end else begin
      pause_valid     <= (fin && is_pfc && idx >= CW'(PFC_LAST)) ? (cev & ~cfg_pfc_ignore) : '0;
      std_pause_valid <= fin && is_std && idx >= CW'(STD_LAST) && !cfg_ignore_std;
    end
  end

  assign std_pause_quanta = std_q;
  for (genvar g = 0; g < NPRIO; g++) begin : g_q
    assign pause_quanta[g*16 +: 16] = qcap[g];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DLY; i++) pipe[i] <= '0;
    end else begin
      pipe[0] <= {in_valid, in_valid && in_sop, in_valid && in_eop, in_valid && in_err, in_data};
      for (int i = 1; i < DLY; i++) pipe[i] <= pipe[i-1];
    end
  end

  wire [11:0] st   = pipe[DLY-1];
  wire        gate = (st[11] && st[10]) ? drop_cls : frame_drop;

  always_ff @(posedge clk) begin
    if (!rst_n)                 frame_drop <= 1'b0;
    else if (st[11] && st[10])  frame_drop <= drop_cls;
  end

  assign out_valid = st[11] && !gate;
  assign out_sop   = out_valid && st[10];
  assign out_eop   = out_valid && st[9];
  assign out_err   = out_valid && st[8];
  assign out_data  = st[7:0];
endmodule

// File: rtl/pfc_rx_filter_chk.sv
module pfc_rx_filter_chk #(
  parameter int NPRIO = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_eop,
  input logic             in_err,
  input logic             cfg_ignore_std,
  input logic [NPRIO-1:0] cfg_pfc_ignore,
  input logic             std_pause_valid,
  input logic [NPRIO-1:0] pause_valid
);
  p_pulse_after_good_eop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (|pause_valid) |-> $past(in_valid && in_eop && !in_err));

  p_pulse_single_cycle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (|pause_valid) |=> (pause_valid == '0));

  p_ignored_lane_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (|pause_valid) |-> ((pause_valid & $past(cfg_pfc_ignore)) == '0));

  p_std_ignore_r7: assert property (@(posedge clk) disable iff (!rst_n)
    std_pause_valid |-> !$past(cfg_ignore_std));

  p_std_after_good_eop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    std_pause_valid |-> $past(in_valid && in_eop && !in_err));

  p_kinds_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(std_pause_valid && (|pause_valid)));
endmodule

bind pfc_rx_filter pfc_rx_filter_chk #(.NPRIO(NPRIO)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_eop(in_eop), .in_err(in_err),
  .cfg_ignore_std(cfg_ignore_std), .cfg_pfc_ignore(cfg_pfc_ignore),
  .std_pause_valid(std_pause_valid), .pause_valid(pause_valid)
);

// File: tb/pfc_rx_filter_bench.sv
module pfc_rx_filter_bench;
  localparam int NP = 4;
  localparam time CLK = 4ns;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 0, in_sop = 0, in_eop = 0, in_err = 0;
  logic [7:0] in_data = 0;
  logic cfg_ignore_std = 0, cfg_fwd_pfc = 0;
  logic [NP-1:0] cfg_pfc_ignore = 0;
  logic out_valid, out_sop, out_eop, out_err, std_pause_valid;
  logic [7:0] out_data;
  logic [15:0] std_pause_quanta;
  logic [NP-1:0] pause_valid;
  logic [NP*16-1:0] pause_quanta;

  always #(CLK/2) clk = ~clk;

  pfc_rx_filter #(.NPRIO(NP)) u_pfc_rx_filter (.*);

  int total = 0, bad = 0;
  logic clr = 0;
  logic [7:0] sent [256];
  int wr_n = 0;
  int rx_n, data_bad, std_n, sop_n;
  logic [NP-1:0] got_mask;
  logic [15:0] got_q [NP];
  logic [15:0] got_stdq;

  always @(negedge clk) begin
    if (clr) begin
      rx_n = 0; data_bad = 0; std_n = 0; sop_n = 0; got_mask = '0; got_stdq = '0;
    end else if (rst_n) begin
      if (out_valid) begin
        if (out_data !== sent[rx_n[7:0]]) data_bad++;
        if (out_sop) sop_n++;
        rx_n++;
      end
      if (|pause_valid) begin
        got_mask = got_mask | pause_valid;
        for (int i = 0; i < NP; i++) if (pause_valid[i]) got_q[i] = pause_quanta[i*16 +: 16];
      end
      if (std_pause_valid) begin std_n++; got_stdq = std_pause_quanta; end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin bad++; $display("FAIL %s actual=%0h expected=%0h", tag, act, exp); end
  endtask

  function automatic logic [15:0] qv(input int i);
    return 16'(16'h1100 * (i + 1) + i);
  endfunction

  function automatic logic [7:0] fb(input int k, input logic [15:0] typ, op, cev);
    if (k < 6) return (k == 0) ? 8'h01 : 8'h20 + 8'(k);
    if (k < 12) return 8'h40 + 8'(k);
    case (k)
      12: return typ[15:8];
      13: return typ[7:0];
      14: return op[15:8];
      15: return op[7:0];
      16: return cev[15:8];
      17: return cev[7:0];
      default: ;
    endcase
    if (k < 34) return (k % 2 == 0) ? qv((k-18)/2) >> 8 : qv((k-18)/2) & 16'hFF;
    return 8'(k * 3);
  endfunction

  task automatic clear_mon();
    @(negedge clk); clr = 1; @(negedge clk); clr = 0; wr_n = 0;
  endtask

  task automatic send(input logic [15:0] typ, op, cev, input int len, input bit err, input bit keep);
    for (int k = 0; k < len; k++) begin
      if (keep) begin sent[wr_n[7:0]] = fb(k, typ, op, cev); wr_n++; end
    end
    for (int k = 0; k < len; k++) begin
      @(negedge clk);
      in_valid = 1; in_sop = (k == 0); in_eop = (k == len - 1);
      in_err = err && (k == len - 1); in_data = fb(k, typ, op, cev);
    end
  endtask

  task automatic idle(input int n);
    @(negedge clk); in_valid = 0; in_sop = 0; in_eop = 0; in_err = 0;
    repeat (n) @(negedge clk);
  endtask

  typedef struct packed {
    logic [15:0] typ, op, cev;
    logic [3:0]  ign;
    logic        fwd, istd, err;
    logic [7:0]  len;
    logic [3:0]  xmask;
    logic [7:0]  xout;
    logic        xstd;
    logic [3:0]  req;
  } row_t;

  localparam int NR = 13;
  localparam row_t ROWS [NR] = '{
    '{16'h8808, 16'h0101, 16'h000F, 4'h0, 1'b0, 1'b0, 1'b0, 8'd64, 4'hF, 8'd0,  1'b0, 4'd2}, // R2 decode, R5 drop
    '{16'h8808, 16'h0101, 16'h00F5, 4'h0, 1'b0, 1'b0, 1'b0, 8'd64, 4'h5, 8'd0,  1'b0, 4'd1}, // R1 upper bits ignored
    '{16'h8808, 16'h0101, 16'h000F, 4'h5, 1'b0, 1'b0, 1'b0, 8'd64, 4'hA, 8'd0,  1'b0, 4'd4}, // R4 per-lane ignore
    '{16'h8808, 16'h0101, 16'h0009, 4'h0, 1'b1, 1'b0, 1'b0, 8'd64, 4'h9, 8'd64, 1'b0, 4'd6}, // R6 forward
    '{16'h8808, 16'h0101, 16'h000F, 4'h0, 1'b0, 1'b0, 1'b1, 8'd64, 4'h0, 8'd0,  1'b0, 4'd3}, // R3 errored
    '{16'h8808, 16'h0101, 16'h000F, 4'hF, 1'b0, 1'b0, 1'b0, 8'd40, 4'h0, 8'd0,  1'b0, 4'd5}, // R5 all ignored, dropped
    '{16'h8808, 16'h0001, 16'h1234, 4'h0, 1'b0, 1'b0, 1'b0, 8'd64, 4'h0, 8'd64, 1'b1, 4'd7}, // R7 standard pause
    '{16'h8808, 16'h0001, 16'h1234, 4'h0, 1'b0, 1'b1, 1'b0, 8'd64, 4'h0, 8'd64, 1'b0, 4'd7}, // R7 ignored
    '{16'h8808, 16'h0003, 16'h000F, 4'h0, 1'b0, 1'b0, 1'b0, 8'd64, 4'h0, 8'd64, 1'b0, 4'd8}, // R8 other opcode
    '{16'h0800, 16'h0101, 16'h000F, 4'h0, 1'b0, 1'b0, 1'b0, 8'd64, 4'h0, 8'd64, 1'b0, 4'd8}, // R8 other type
    '{16'h8808, 16'h0101, 16'h000F, 4'h0, 1'b0, 1'b0, 1'b0, 8'd30, 4'h0, 8'd0,  1'b0, 4'd3}, // R3 truncated
    '{16'h8808, 16'h0101, 16'h000F, 4'h0, 1'b0, 1'b0, 1'b0, 8'd10, 4'h0, 8'd10, 1'b0, 4'd8}, // R8 shorter than header
    '{16'h8808, 16'h0101, 16'h0006, 4'h0, 1'b0, 1'b0, 1'b0, 8'd34, 4'h6, 8'd0,  1'b0, 4'd3}  // R3 minimum length
  };

  initial begin
    #(CLK * 200000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int lat;
    repeat (4) @(negedge clk);
    rst_n = 1;
    clear_mon();
    chk(out_valid == 0 && pause_valid == 0 && std_pause_valid == 0, "reset R8", out_valid, 0);

    for (int r = 0; r < NR; r++) begin
      string tag;
      row_t w;
      w = ROWS[r];
      tag = $sformatf("row%0d R%0d", r, w.req);
      cfg_pfc_ignore = w.ign; cfg_fwd_pfc = w.fwd; cfg_ignore_std = w.istd;
      clear_mon();
      send(w.typ, w.op, w.cev, int'(w.len), w.err, w.xout != 0);
      idle(24);
      chk(rx_n == int'(w.xout), {tag, " bytes out"}, rx_n, w.xout);
      chk(got_mask == w.xmask, {tag, " lanes"}, got_mask, w.xmask);
      chk(std_n == int'(w.xstd), {tag, " std pulses"}, std_n, w.xstd);
      if (w.xout != 0) chk(data_bad == 0 && sop_n == 1, {tag, " data"}, data_bad, 0);
      for (int i = 0; i < NP; i++)
        if (w.xmask[i]) chk(got_q[i] == qv(i), {tag, " quanta"}, got_q[i], qv(i));
      if (w.xstd) chk(got_stdq == w.cev, {tag, " std quanta"}, got_stdq, w.cev);
    end
    cfg_pfc_ignore = 0; cfg_fwd_pfc = 0; cfg_ignore_std = 0;

    // R8 latency: accepted at first edge, visible after the sixteenth
    clear_mon();
    @(negedge clk);
    in_valid = 1; in_sop = 1; in_eop = 1; in_data = 8'h5A;
    @(posedge clk); lat = 1;
    @(negedge clk); in_valid = 0; in_sop = 0; in_eop = 0;
    while (!out_valid && lat < 40) begin @(posedge clk); lat++; @(negedge clk); end
    chk(lat == 16, "latency R8", lat, 16);
    idle(20);

    // R5/R8 dropped PFC frame followed at once by a short data frame
    clear_mon();
    send(16'h8808, 16'h0101, 16'h0003, 64, 1'b0, 1'b0);
    send(16'h0800, 16'h0000, 16'h0000, 12, 1'b0, 1'b1);
    idle(24);
    chk(rx_n == 12 && data_bad == 0, "back-to-back R5 R8", rx_n, 12);
    chk(got_mask == 4'h3, "back-to-back lanes R3", got_mask, 3);

    // R8 error flag carried on a forwarded frame
    clear_mon();
    send(16'h0800, 16'h0000, 16'h0000, 20, 1'b1, 1'b1);
    fork
      begin
        int seen = 0;
        repeat (40) begin @(negedge clk); if (out_eop && out_err) seen = 1; end
        chk(seen == 1, "error passthrough R8", seen, 1);
      end
      idle(39);
    join

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule